// File: doc/BRIEF.md
# Block-Transfer Serial Configuration Slave

This block is a two-wire serial slave that holds a small bank of 8-bit configuration registers, each with a fixed reset value. It answers a single 7-bit device address, 0x69. The bus lines SCL and SDA are sampled in a fast system clock domain. SDA is driven through an open-drain enable. The bus speed is up to 100 kbit/s, bytes are 8 bits and each byte is sent most significant bit first.

Only whole-bank transfers exist, and addressing always starts at register 0 and counts up.
- **Write:** the master sends the address with R/W = 0, then two header bytes that are acknowledged and discarded, then data bytes that land in register 0, 1, 2 and so on.
- **Read:** the master sends the address with R/W = 1, and the slave returns a byte count followed by the registers in ascending order.

Four frequency-select strap inputs are captured while reset is held. They can be read back through register 6. A control bit in register 0 chooses whether the `freq_sel` output follows the captured straps or a programmed field.

Top module: `cfg_serial_slave`

## Requirements
- R1: While `rst` is high and on the cycle after it, `sda_oe` is 0. Reset loads register 0 and register 6 with 0x00 and registers 1 to 5 with 0xFF. Register i occupies `cfg_regs[8*i+7:8*i]`.
- R2: `strap_fs` is captured on every clock while `rst` is high. Changes after reset are ignored. When register 0 bit 3 is 0, `freq_sel` equals the captured straps.
- R3: When register 0 bit 3 is 1, `freq_sel` equals register 0 bits 7:4.
- R4: Address bytes 0xD2 (write) and 0xD3 (read) are acknowledged by holding SDA low during the ninth clock. Any other address byte is not acknowledged, and the slave ignores the bus until the next START.
- R5: In a write, the first two bytes after the address are acknowledged and discarded. The following bytes are acknowledged and stored into register 0, 1, ... 6 in ascending order.
- R6: A STOP after any complete byte keeps every register already written, and leaves all the other registers unchanged.
- R7: Write data bytes beyond register 6 are acknowledged and discarded.
- R8: A read returns 0x07 first, then registers 0 to 6. Register 0 reads back as {1, 0, 0, 1, bit 3, 0, bits 1:0}: bits 7, 6:4 and 2 carry the fixed revision code 5'b10010, given in the order 7, 6, 5, 4, 2. Register 6 reads back its stored bits 7:4 with the captured straps in bits 3:0.
- R9: A read continuing past register 6 returns 0xFF.
- R10: A master NACK ends a read. The slave then keeps SDA released until the next START.
- R11: A START or STOP in the middle of a byte abandons the transfer. The partial byte is not stored, and a following write starts again at register 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset; straps are captured while it is high |
| scl_in | input | 1 | Bus clock line as seen on the pin |
| sda_in | input | 1 | Bus data line as seen on the pin |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| strap_fs | input | 4 | Frequency-select strap inputs |
| cfg_regs | output | 56 | Stored register bank, register i at bits 8*i+7:8*i |
| freq_sel | output | 4 | Selected frequency code |

## Verification
A wrong bit counter or state shows up at the ports within one byte time:
- An acknowledge lands on the wrong clock, or goes missing, and the driver sees this at the ninth clock.
- Read data comes out shifted, and the scoreboard flags the first corrupted byte.

A wrong register index after the header bytes, or a counter that is not cleared on an abort, puts data into the wrong slot of `cfg_regs`. This is visible as soon as the STOP is seen. A stale strap latch or select bit is visible at once on `freq_sel`.

// File: rtl/cfg_slave_pkg.sv
package cfg_slave_pkg;
    localparam int          BYTE_W   = 8;
    localparam logic [6:0]  DEV_ADDR = 7'h69;
    // revision bits in read-back order: bit7, bit6, bit5, bit4, bit2
    localparam logic [4:0]  REV_CODE = 5'b10010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK
    } link_st_e;

    function automatic logic [7:0] reg_default(input int idx, input int nreg);
        return (idx == 0 || idx == nreg - 1) ? 8'h00 : 8'hFF;
    endfunction
endpackage

// File: rtl/cfg_line_sync.sv
module cfg_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic cur,
    output logic prev
);
    logic [STAGES:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) pipe <= '1;
        else     pipe <= {pipe[STAGES-1:0], din};
    end

    assign cur  = pipe[STAGES-1];
    assign prev = pipe[STAGES];
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank import cfg_slave_pkg::*; #(
    parameter int NREG  = 7,
    parameter int CNT_W = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [CNT_W-1:0]       wr_idx,
    input  logic [BYTE_W-1:0]      wr_data,
    output logic [NREG*BYTE_W-1:0] regs
);
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [BYTE_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst)                                  q <= reg_default(g, NREG);
            else if (wr_en && wr_idx == CNT_W'(g))    q <= wr_data;
        end
        assign regs[g*BYTE_W +: BYTE_W] = q;
    end
endmodule

// File: rtl/cfg_link_fsm.sv
module cfg_link_fsm import cfg_slave_pkg::*; #(
    parameter int NREG  = 7,
    parameter int CNT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_ev,
    input  logic              stop_ev,
    input  logic              sda_s,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [CNT_W-1:0]  byte_no,
    output logic              sda_oe,
    output logic              wr_en,
    output logic [CNT_W-1:0]  wr_idx,
    output logic [BYTE_W-1:0] wr_data,
    output link_st_e          st
);
    logic [BYTE_W-1:0] sh;
    logic [3:0]        bitcnt;
    logic              is_addr, rd_mode, m_ack;
    logic [CNT_W-1:0]  data_idx;
    logic              wr_ok, at_max;

    always_comb begin
        data_idx = byte_no - CNT_W'(2);
        wr_ok    = (byte_no >= CNT_W'(2)) && (data_idx < CNT_W'(NREG));
        at_max   = &byte_no;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            sh      <= '0;
            bitcnt  <= '0;
            byte_no <= '0;
            is_addr <= 1'b0;
            rd_mode <= 1'b0;
            m_ack   <= 1'b0;
            sda_oe  <= 1'b0;
            wr_en   <= 1'b0;
            wr_idx  <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (start_ev) begin
                st      <= ST_RX;
                bitcnt  <= '0;
                byte_no <= '0;
                is_addr <= 1'b1;
                sda_oe  <= 1'b0;
            end else if (stop_ev) begin
                st     <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                unique case (st)
                    ST_RX: begin
                        if (scl_rise && bitcnt != 4'd8) begin
                            sh     <= {sh[BYTE_W-2:0], sda_s};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (scl_fall && bitcnt == 4'd8) begin
                            if (is_addr) begin
                                if (sh[7:1] == DEV_ADDR) begin
                                    sda_oe  <= 1'b1;
                                    rd_mode <= sh[0];
                                    st      <= ST_ACK;
                                end else begin
                                    st <= ST_IDLE;
                                end
                            end else begin
                                sda_oe <= 1'b1;
                                st     <= ST_ACK;
                                if (wr_ok) begin
                                    wr_en   <= 1'b1;
                                    wr_idx  <= data_idx;
                                    wr_data <= sh;
                                end
                                if (!at_max) byte_no <= byte_no + CNT_W'(1);
                            end
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            is_addr <= 1'b0;
                            bitcnt  <= '0;
                            if (rd_mode) begin
                                sh     <= rd_data;
                                sda_oe <= ~rd_data[7];
                                st     <= ST_TX;
                            end else begin
                                sda_oe <= 1'b0;
                                st     <= ST_RX;
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_rise) begin
                            bitcnt <= bitcnt + 4'd1;
                        end else if (scl_fall) begin
                            if (bitcnt == 4'd8) begin
                                sda_oe <= 1'b0;
                                st     <= ST_MACK;
                                if (!at_max) byte_no <= byte_no + CNT_W'(1);
                            end else begin
                                sh     <= {sh[BYTE_W-2:0], 1'b0};
                                sda_oe <= ~sh[6];
                            end
                        end
                    end
                    ST_MACK: begin
                        if (scl_rise) begin
                            m_ack <= ~sda_s;
                        end else if (scl_fall) begin
                            bitcnt <= '0;
                            if (m_ack) begin
                                sh     <= rd_data;
                                sda_oe <= ~rd_data[7];
                                st     <= ST_TX;
                            end else begin
                                sda_oe <= 1'b0;
                                st     <= ST_IDLE;
                            end
                        end
                    end
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/cfg_serial_slave.sv
module cfg_serial_slave import cfg_slave_pkg::*; #(
    parameter int NREG      = 7,
    parameter int SYNC_DEPTH = 2,
    parameter int STRAP_W   = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   scl_in,
    input  logic                   sda_in,
    output logic                   sda_oe,
    input  logic [STRAP_W-1:0]     strap_fs,
    output logic [NREG*BYTE_W-1:0] cfg_regs,
    output logic [STRAP_W-1:0]     freq_sel
);
    localparam int CNT_W = $clog2(NREG + 4);

    logic scl_c, scl_p, sda_c, sda_p;
    logic scl_rise, scl_fall, start_ev, stop_ev;
    logic [CNT_W-1:0]  byte_no, wr_idx, rd_sel;
    logic              wr_en;
    logic [BYTE_W-1:0] wr_data, rd_data, reg0;
    logic [STRAP_W-1:0] strap_q;
    link_st_e          link_state;

    cfg_line_sync #(.STAGES(SYNC_DEPTH)) u_scl (
        .clk(clk), .rst(rst), .din(scl_in), .cur(scl_c), .prev(scl_p));
    cfg_line_sync #(.STAGES(SYNC_DEPTH)) u_sda (
        .clk(clk), .rst(rst), .din(sda_in), .cur(sda_c), .prev(sda_p));

    assign scl_rise = scl_c & ~scl_p;
    assign scl_fall = ~scl_c & scl_p;
    assign start_ev = scl_c & scl_p & sda_p & ~sda_c;
    assign stop_ev  = scl_c & scl_p & ~sda_p & sda_c;

    always_ff @(posedge clk) begin
        if (rst) strap_q <= strap_fs;
    end

    cfg_link_fsm #(.NREG(NREG), .CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst(rst), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_ev(start_ev), .stop_ev(stop_ev), .sda_s(sda_c),
        .rd_data(rd_data), .byte_no(byte_no), .sda_oe(sda_oe),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .st(link_state));

    cfg_reg_bank #(.NREG(NREG), .CNT_W(CNT_W)) u_bank (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .regs(cfg_regs));

    assign reg0 = cfg_regs[BYTE_W-1:0];

    always_comb begin
        rd_sel  = byte_no - CNT_W'(1);
        rd_data = 8'hFF;
        if (byte_no == '0) begin
            rd_data = 8'(NREG);
        end else if (byte_no <= CNT_W'(NREG)) begin
            rd_data = cfg_regs[{rd_sel, 3'b000} +: BYTE_W];
            if (rd_sel == '0)
                rd_data = {REV_CODE[4], REV_CODE[3:1], reg0[3], REV_CODE[0], reg0[1:0]};
            if (rd_sel == CNT_W'(NREG - 1))
                rd_data[STRAP_W-1:0] = strap_q;
        end
    end

    assign freq_sel = reg0[3] ? reg0[7:4] : strap_q;
endmodule

// File: rtl/cfg_slave_chk.sv
module cfg_slave_chk import cfg_slave_pkg::*; #(
    parameter int NREG  = 7,
    parameter int CNT_W = 4
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   sda_oe,
    input logic [3:0]             strap_q,
    input logic                   wr_en,
    input logic [CNT_W-1:0]       wr_idx,
    input logic [BYTE_W-1:0]      wr_data,
    input logic [NREG*BYTE_W-1:0] cfg_regs,
    input logic                   stop_ev,
    input link_st_e               link_state
);
    logic              wr_q;
    logic [CNT_W-1:0]  idx_q;
    logic [BYTE_W-1:0] dat_q;
    logic [BYTE_W-1:0] sel_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q  <= 1'b0;
            idx_q <= '0;
            dat_q <= '0;
        end else begin
            wr_q  <= wr_en;
            idx_q <= wr_idx;
            dat_q <= wr_data;
        end
    end

    assign sel_now = cfg_regs[{idx_q, 3'b000} +: BYTE_W];

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (!sda_oe && cfg_regs[7:0] == 8'h00));

    assert_strap_hold_R2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(strap_q));

    assert_write_lands_R5: assert property (@(posedge clk) disable iff (rst)
        wr_q |-> sel_now == dat_q);

    assert_idle_released_R10: assert property (@(posedge clk) disable iff (rst)
        link_state == ST_IDLE |-> !sda_oe);

    assert_stop_aborts_R11: assert property (@(posedge clk) disable iff (rst)
        stop_ev |=> (link_state == ST_IDLE && !wr_en));
endmodule

bind cfg_serial_slave cfg_slave_chk #(.NREG(NREG), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .sda_oe(sda_oe), .strap_q(strap_q),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .cfg_regs(cfg_regs), .stop_ev(stop_ev), .link_state(link_state));

// File: tb/sim_cfg_serial_slave.sv
module sim_cfg_serial_slave;
    localparam int CLK_P = 10;
    localparam int Q     = 10;
    localparam int NR    = 7;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic [3:0] strap = 4'hA;
    logic sda_oe;
    logic [NR*8-1:0] cfg_regs;
    logic [3:0] freq_sel;
    wire  sda_line = sda_m & ~sda_oe;

    int nchk = 0, nerr = 0;
    logic [7:0] mreg [NR];
    logic [7:0] exp_v[$];
    string      exp_tag[$];
    logic [7:0] obs;
    event       obs_ev;

    always #(CLK_P/2) clk = ~clk;

    cfg_serial_slave u0 (
        .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_line),
        .sda_oe(sda_oe), .strap_fs(strap), .cfg_regs(cfg_regs), .freq_sel(freq_sel));

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // scoreboard monitor
    initial forever begin
        @(obs_ev);
        if (exp_v.size() == 0) chk("R8 unexpected byte", {56'd0, obs}, 64'hFFFF);
        else chk(exp_tag.pop_front(), {56'd0, obs}, {56'd0, exp_v.pop_front()});
    end

    function automatic logic [NR*8-1:0] mflat();
        logic [NR*8-1:0] f;
        for (int i = 0; i < NR; i++) f[i*8 +: 8] = mreg[i];
        return f;
    endfunction

    function automatic logic [3:0] mfreq();
        return mreg[0][3] ? mreg[0][7:4] : 4'hA;
    endfunction

    // read-back per R8
    function automatic logic [7:0] rb(int i);
        if (i == 0) return {1'b1, 3'b001, mreg[0][3], 1'b0, mreg[0][1:0]};
        if (i == NR - 1) return {mreg[i][7:4], 4'hA};
        return mreg[i];
    endfunction

    task automatic qw(); repeat (Q) @(negedge clk); endtask

    task automatic bus_start();
        sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); sda_m = 1'b0; qw(); scl_m = 1'b0; qw();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; qw(); scl_m = 1'b1; qw(); sda_m = 1'b1; qw();
    endtask

    task automatic send_bit(logic b);
        sda_m = b; qw(); scl_m = 1'b1; qw(); qw(); scl_m = 1'b0; qw();
    endtask

    task automatic recv_bit(output logic b);
        sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); b = sda_line; qw(); scl_m = 1'b0; qw();
    endtask

    task automatic send_byte(logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(b);
        ack = ~b;
    endtask

    task automatic recv_byte(output logic [7:0] v, input logic mack);
        for (int i = 7; i >= 0; i--) recv_bit(v[i]);
        send_bit(~mack);
    endtask

    task automatic write_seq(logic [7:0] d[$], logic exp_ack, string tag);
        logic a;
        bus_start();
        send_byte(8'hD2, a); chk({tag, " addr ack"}, {63'd0, a}, {63'd0, exp_ack});
        send_byte(8'h5C, a); chk({tag, " cmd ack"}, {63'd0, a}, {63'd0, exp_ack});
        send_byte(8'h07, a); chk({tag, " count ack"}, {63'd0, a}, {63'd0, exp_ack});
        foreach (d[i]) begin
            send_byte(d[i], a);
            chk({tag, " data ack"}, {63'd0, a}, {63'd0, exp_ack});
            if (i < NR) mreg[i] = d[i];
        end
        bus_stop();
    endtask

    task automatic read_seq(int n, string tag);
        logic a;
        logic [7:0] v;
        for (int i = 0; i < n; i++) begin
            exp_v.push_back(i == 0 ? 8'd7 : (i <= NR ? rb(i - 1) : 8'hFF));
            exp_tag.push_back(i > NR ? "R9 past end" : tag);
        end
        bus_start();
        send_byte(8'hD3, a); chk("R4 read addr ack", {63'd0, a}, 64'd1);
        for (int i = 0; i < n; i++) begin
            recv_byte(v, i != n - 1);
            obs = v; ->obs_ev;
        end
        bus_stop();
    endtask

    initial begin
        repeat (2000 * Q * 10) @(posedge clk);
        nerr++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        logic a;
        logic [7:0] v;
        for (int i = 0; i < NR; i++) mreg[i] = (i == 0 || i == NR - 1) ? 8'h00 : 8'hFF;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        strap = 4'h5; // R2: must be ignored now
        repeat (3) @(negedge clk);
        chk("R1 reset regs", cfg_regs, mflat());
        chk("R1 sda released", {63'd0, sda_oe}, 64'd0);
        chk("R2 strap latched", {60'd0, freq_sel}, 64'hA);

        // R5 full write
        write_seq('{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h77}, 1'b1, "R5");
        chk("R5 regs after write", cfg_regs, mflat());
        chk("R2 freq from straps", {60'd0, freq_sel}, {60'd0, mfreq()});

        // R8 read full bank
        read_seq(NR + 1, "R8 read data");

        // R6 partial write, R3 programmed select
        write_seq('{8'hC8, 8'hBB}, 1'b1, "R6");
        chk("R6 partial regs", cfg_regs, mflat());
        chk("R3 programmed freq", {60'd0, freq_sel}, 64'hC);
        read_seq(NR + 3, "R8 read after partial");

        // R7 overflow write
        write_seq('{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08, 8'h09}, 1'b1, "R7");
        chk("R7 overflow discarded", cfg_regs, mflat());
        chk("R2 freq back to straps", {60'd0, freq_sel}, 64'hA);

        // R4 wrong address
        bus_start();
        send_byte(8'hA4, a); chk("R4 wrong addr nack", {63'd0, a}, 64'd0);
        send_byte(8'h00, a); chk("R4 ignored byte", {63'd0, a}, 64'd0);
        send_byte(8'hD2, a); chk("R4 addr mid-frame ignored", {63'd0, a}, 64'd0);
        send_byte(8'hEE, a);
        bus_stop();
        chk("R4 regs unchanged", cfg_regs, mflat());

        // R10 master nack ends read
        exp_v.push_back(8'd7); exp_tag.push_back("R10 count");
        exp_v.push_back(rb(0)); exp_tag.push_back("R10 reg0");
        bus_start();
        send_byte(8'hD3, a); chk("R4 read addr", {63'd0, a}, 64'd1);
        recv_byte(v, 1'b1); obs = v; ->obs_ev;
        recv_byte(v, 1'b0); obs = v; ->obs_ev;
        recv_byte(v, 1'b0);
        chk("R10 released after nack", {56'd0, v}, 64'hFF);
        bus_stop();

        // R11 mid-byte stop
        bus_start();
        send_byte(8'hD2, a); send_byte(8'h00, a); send_byte(8'h00, a);
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
        bus_stop();
        chk("R11 stop mid-byte", cfg_regs, mflat());

        // R11 mid-byte start, then fresh write begins at register 0
        bus_start();
        send_byte(8'hD2, a); send_byte(8'h00, a); send_byte(8'h00, a);
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
        write_seq('{8'h5A}, 1'b1, "R11");
        chk("R11 restart at reg0", cfg_regs, mflat());
        chk("R3 programmed freq 5", {60'd0, freq_sel}, 64'h5);

        repeat (20) @(negedge clk);
        chk("R8 scoreboard drained", {32'd0, 32'(exp_v.size())}, 64'd0);
        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule